// File: doc/BRIEF.md
# Serial-In Shift Register with Recirculating Parallel Store

This block pairs a serial shift register with a parallel storage register of the same width. Serial data enters the low end of the shift register. The top stage drives a serial output, so several instances can be chained into longer words. A transfer strobe copies the whole shift register into the storage register, whose bits appear on the parallel outputs. Another mode loads the storage register back into the shift register, so a stored word can be shifted out again.

The block runs on one system clock. Both strobe pins (shift and store) and the control pins are sampled through the same synchronizer, so a strobe and the controls that qualify it always stay aligned. A strobe changes state only on its detected edge: the shift strobe on its high-to-low edge, the store strobe on its low-to-high edge. A change of level on chip select or on read/write is never taken as a strobe edge. The level of the store strobe does a second job. In read mode it chooses between shifting and reloading when a shift edge arrives.

Top module: `serial_store_reg`

## Requirements
- R1: A synchronous active-high reset clears the shift register, the storage register and the edge history, so `par_out` and `ser_out` read 0 after reset.
- R2: While `cs_n` is 1, neither register changes, whatever the strobes do.
- R3: With `cs_n`=0 and `rw`=0, a falling edge of `shift_clk` moves each shift bit i to bit i+1, and `ser_in` enters bit 0.
- R4: With `cs_n`=0, `rw`=1 and `store_clk` at 0, a falling edge of `shift_clk` shifts exactly as in R3.
- R5: With `cs_n`=0, `rw`=1 and `store_clk` at 1, a falling edge of `shift_clk` copies the storage register into the shift register, and no shift takes place.
- R6: With `cs_n`=0 and `rw`=0, a rising edge of `store_clk` copies the shift register into the storage register, which drives `par_out`.
- R7: While `rw` is 1, the storage register holds on every `store_clk` edge.
- R8: Only the stated strobe edges change state. A rising `shift_clk` edge, a falling `store_clk` edge and level changes on `cs_n` or `rw` (with the strobes held) leave both registers unchanged.
- R9: `ser_out` always equals the top bit (bit WIDTH-1) of the shift register, so it can feed `ser_in` of the next block in a chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data into shift bit 0 |
| cs_n | input | 1 | Chip select, active low |
| rw | input | 1 | 1 = read (storage holds), 0 = write |
| shift_clk | input | 1 | Shift strobe, acts on its falling edge |
| store_clk | input | 1 | Store strobe, acts on its rising edge; its level selects reload in read mode |
| ser_out | output | 1 | Top bit of the shift register |
| par_out | output | WIDTH | Storage register contents |

## Verification
The assertions check on every cycle the next-state rules of both registers. When the synchronized controls say shift, reload, store or hold, the following cycle must show that exact result. With no qualifying edge, both registers must stay unchanged. The bench scenarios show what only a sequence of strobes can show. A whole word shifted in comes out on the parallel pins. A reloaded word comes back out of `ser_out` bit by bit in order. Toggling chip select or read/write while a strobe sits at a level produces no phantom edge.

// File: rtl/serial_store_reg.sv
module serial_store_reg #(
  parameter int WIDTH       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_in,
  input  logic             cs_n,
  input  logic             rw,
  input  logic             shift_clk,
  input  logic             store_clk,
  output logic             ser_out,
  output logic [WIDTH-1:0] par_out
);

  localparam int NSIG  = 5;
  localparam int B_SI  = 4;
  localparam int B_CS  = 3;
  localparam int B_RW  = 2;
  localparam int B_SHF = 1;
  localparam int B_STC = 0;

  logic [NSIG-1:0]  sync_q [SYNC_STAGES];
  logic [NSIG-1:0]  smp;
  logic             shf_prev, stc_prev;
  logic             shf_fall, stc_rise;
  logic             sel, wr_mode, reload;
  logic [WIDTH-1:0] shift_q, store_q;

  assign smp = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      shf_prev <= 1'b0;
      stc_prev <= 1'b0;
    end else begin
      sync_q[0] <= {ser_in, cs_n, rw, shift_clk, store_clk};
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      shf_prev <= smp[B_SHF];
      stc_prev <= smp[B_STC];
    end
  end

  assign shf_fall = shf_prev & ~smp[B_SHF];
  assign stc_rise = ~stc_prev & smp[B_STC];
  assign sel      = ~smp[B_CS];
  assign wr_mode  = sel & ~smp[B_RW];
  assign reload   = sel & smp[B_RW] & smp[B_STC];

  always_ff @(posedge clk) begin
    if (rst)                shift_q <= '0;
    else if (sel && shf_fall)
      shift_q <= reload ? store_q : {shift_q[WIDTH-2:0], smp[B_SI]};
  end

  always_ff @(posedge clk) begin
    if (rst)                       store_q <= '0;
    else if (wr_mode && stc_rise)  store_q <= shift_q;
  end

  assign ser_out = shift_q[WIDTH-1];
  assign par_out = store_q;

  AST_DESELECT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sel |=> ($stable(shift_q) && $stable(store_q))); // R2

  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
    (sel && shf_fall && !reload) |=>
      (shift_q == {$past(shift_q[WIDTH-2:0]), $past(smp[B_SI])})); // R3

  AST_RELOAD: assert property (@(posedge clk) disable iff (rst)
    (sel && shf_fall && reload) |=> (shift_q == $past(store_q))); // R5

  AST_STORE_COPY: assert property (@(posedge clk) disable iff (rst)
    (wr_mode && stc_rise) |=> (par_out == $past(shift_q))); // R6

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (rst)
    smp[B_RW] |=> $stable(store_q)); // R7

  AST_NO_EDGE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    !shf_fall |=> $stable(shift_q)); // R8

  AST_NO_EDGE_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    !stc_rise |=> $stable(store_q)); // R8

endmodule

// File: tb/tb_serial_store_reg.sv
module tb_serial_store_reg;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_in = 1'b0, cs_n = 1'b0, rw = 1'b0;
  logic shift_clk = 1'b0, store_clk = 1'b0;
  logic ser_out;
  logic [W-1:0] par_out;

  logic [W-1:0] exp_sh = '0, exp_st = '0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  serial_store_reg #(.WIDTH(W), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .ser_in(ser_in), .cs_n(cs_n), .rw(rw),
    .shift_clk(shift_clk), .store_clk(store_clk),
    .ser_out(ser_out), .par_out(par_out));

  always #10 clk = ~clk;

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_pulse(input logic b);
    ser_in = b;
    shift_clk = 1'b1; settle();
    shift_clk = 1'b0; settle();
    if (!cs_n) exp_sh = (rw && store_clk) ? exp_st : {exp_sh[W-2:0], b};
  endtask

  task automatic store_pulse();
    store_clk = 1'b1; settle();
    if (!cs_n && !rw) exp_st = exp_sh;
    store_clk = 1'b0; settle();
  endtask

  task automatic t_reset();
    chk("R1 par_out", par_out, '0);
    chk("R1 ser_out", {{(W-1){1'b0}}, ser_out}, '0);
  endtask

  task automatic t_write_shift(input logic [W-1:0] word);
    cs_n = 1'b0; rw = 1'b0; store_clk = 1'b0; settle();
    for (int i = W-1; i >= 0; i--) begin
      shift_pulse(word[i]);
      chk("R3/R9 ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, exp_sh[W-1]});
    end
    chk("R3 par_out before store", par_out, exp_st);
    store_pulse();
    chk("R6 stored word", par_out, word);
  endtask

  task automatic t_read_shift(input logic [W-1:0] word);
    cs_n = 1'b0; rw = 1'b1; store_clk = 1'b0; settle();
    for (int i = W-1; i >= 0; i--) shift_pulse(word[i]);
    chk("R4 ser_out after read shift", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, word[W-1]});
    store_pulse();
    chk("R7 storage holds in read", par_out, exp_st);
    rw = 1'b0; settle();
    store_pulse();
    chk("R4 shifted word", par_out, word);
  endtask

  task automatic t_reload(input logic [W-1:0] stored, input logic [W-1:0] other);
    logic [W-1:0] got;
    t_write_shift(stored);
    cs_n = 1'b0; rw = 1'b0; store_clk = 1'b0; settle();
    for (int i = W-1; i >= 0; i--) shift_pulse(other[i]);
    rw = 1'b1; settle();
    store_clk = 1'b1; settle();
    shift_pulse(1'b0);
    store_clk = 1'b0; settle();
    chk("R5 par_out unchanged", par_out, stored);
    rw = 1'b0; settle();
    got = '0;
    for (int i = 0; i < W; i++) begin
      got = {got[W-2:0], ser_out};
      shift_pulse(1'b0);
    end
    chk("R5 reloaded word shifted out", got, stored);
  endtask

  task automatic t_deselect();
    logic [W-1:0] before_sh;
    before_sh = exp_sh;
    cs_n = 1'b1; rw = 1'b0; settle();
    shift_pulse(1'b1); shift_pulse(1'b0);
    store_pulse();
    chk("R2 par_out held", par_out, exp_st);
    cs_n = 1'b0; settle();
    store_pulse();
    chk("R2 shift reg held", par_out, before_sh);
  endtask

  task automatic t_levels_only(input logic [W-1:0] word);
    t_write_shift(word);
    cs_n = 1'b0; rw = 1'b0; settle();
    for (int i = W-1; i >= 0; i--) shift_pulse(~word[i]);
    shift_clk = 1'b1; settle();
    chk("R8 rising shift edge", par_out, word);
    cs_n = 1'b1; settle(); cs_n = 1'b0; settle();
    rw = 1'b1; settle(); rw = 1'b0; settle();
    shift_clk = 1'b0; exp_sh = {exp_sh[W-2:0], ser_in}; settle();
    store_clk = 1'b1; exp_st = exp_sh; settle();
    chk("R6 store after shift edge", par_out, exp_st);
    cs_n = 1'b1; settle(); cs_n = 1'b0; settle();
    rw = 1'b1; settle(); rw = 1'b0; settle();
    store_clk = 1'b0; settle();
    chk("R8 level changes ignored", par_out, exp_st);
    chk("R8/R9 ser_out", {{(W-1){1'b0}}, ser_out}, {{(W-1){1'b0}}, exp_sh[W-1]});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle();
    t_reset();
    t_write_shift(16'hA5C3);
    t_read_shift(16'h3C96);
    t_reload(16'hB7E1, 16'h1248);
    t_deselect();
    t_levels_only(16'h5F0A);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule